// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is an up-counting watchdog. Its count advances on a slow timer tick, which the block sees as a one-cycle enable on the system clock. When the count passes all-ones, the counter reloads itself from a load register and drives a one-cycle reset request. Software keeps the system alive by writing a new value to a service register. Any value that differs from the one already stored there reloads the count at once.

The timer can be stopped or started only by a pair of keyed writes to a run-control register. Each such write is posted. A pending flag stays set until the word has been taken in on a timer tick. While the timer runs, the load, prescaler and counter registers are locked. Load and prescaler values written while the timer is stopped are not used at once. They take effect at the next reload, whether it comes from an overflow or from a service write. Reading the low half of the counter captures the whole count, so a later read of the high half is consistent with it.

Top module: `keyed_wdt`

Register map (word addresses on `addr`): 0 run control, 1 service, 2 load, 3 prescaler control, 4 counter (read: low 16 bits, write: full count), 5 captured counter high half, 6 status (bit 0 = run-control write pending), 7 reads zero.

## Requirements
- R1: After reset the timer is running, the counter and the load register hold 0xFFFF0000, and the prescaler control, service register, posted word and pending flag all read 0. The reset request then asserts after exactly 65536 timer ticks.
- R2: While running with the prescaler off, the counter increments by one on every cycle in which tick_en is high. It holds when tick_en is low or the timer is stopped.
- R3: Prescaler control bit 5 enables the prescaler, and bits 4:2 hold the exponent P. When enabled, the count advances once every 2^P ticks of a running timer.
- R4: Only the low 16 bits of a run-control word count. 0xAAAA followed by 0x5555 stops the timer, and 0xBBBB followed by 0x4444 starts it. A first key followed by any other word drops the sequence, and if that word is itself a first key, a new sequence starts from it. No other sequence changes the run state.
- R5: A write to run control sets the pending flag (status bit 0). The posted word is applied, and the flag cleared, on the next cycle in which tick_en is high.
- R6: A service write whose value differs from the stored one reloads the counter from the load register, clears the prescaler and raises no reset request. A write of the same value has no effect on the counter.
- R7: When an advance finds the counter at all-ones, the counter reloads from the load register, the prescaler clears, and wdt_rst_o is high for the next cycle only.
- R8: New load and prescaler values take effect only at the next reload, whether from overflow or from a service write. Restarting the timer alone does not apply them.
- R9: Writes to the load, prescaler control and counter registers are ignored while the timer runs. While it is stopped, a counter write sets the full count.
- R10: A read of address 4 returns the live low half and captures the whole count. Address 5 returns the high half of that capture until the next such read.
- R11: If a changing service write falls in the same cycle as an overflow advance, the counter reloads once and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle timer tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| wdt_rst_o | output | 1 | One-cycle reset request on overflow |

## Verification
A service write and an overflow can land in the same cycle. This happens when the counter sits at all-ones and a tick arrives together with a changing service value. Both events ask for a reload, but only the overflow asks for a reset request. The bench sets this up directly by stopping the timer, writing all-ones into the counter and restarting it. It then issues the service write and the tick in one cycle, and expects a single reload with wdt_rst_o held low. Random traffic also produces such overlaps, and they are judged by a cycle model that gives the service write priority.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int KEY_W = 16;

  typedef enum logic [2:0] {
    A_RUNCTL = 3'd0,
    A_SERVICE = 3'd1,
    A_LOAD = 3'd2,
    A_PSC = 3'd3,
    A_CNT = 3'd4,
    A_CNTHI = 3'd5,
    A_STAT = 3'd6
  } reg_addr_e;

  localparam logic [KEY_W-1:0] KEY_STOP_A = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_STOP_B = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_GO_A = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_GO_B = 16'h4444;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_STOP = 2'd1,
    SEQ_GO = 2'd2
  } seq_e;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             post_wr,
  input  logic [KEY_W-1:0] post_word,
  output logic             running,
  output logic             pend,
  output logic [KEY_W-1:0] posted
);
  seq_e             state_q, state_d;
  logic             run_q, run_d;
  logic             pend_q, pend_d;
  logic [KEY_W-1:0] word_q, word_d;
  logic             absorb;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    pend_d  = pend_q;
    word_d  = word_q;
    absorb  = pend_q & tick;
    if (absorb) begin
      if (state_q == SEQ_STOP && word_q == KEY_STOP_B) begin
        run_d   = 1'b0;
        state_d = SEQ_IDLE;
      end else if (state_q == SEQ_GO && word_q == KEY_GO_B) begin
        run_d   = 1'b1;
        state_d = SEQ_IDLE;
      end else if (word_q == KEY_STOP_A) begin
        state_d = SEQ_STOP;
      end else if (word_q == KEY_GO_A) begin
        state_d = SEQ_GO;
      end else begin
        state_d = SEQ_IDLE;
      end
    end
    if (post_wr) begin
      word_d = post_word;
      pend_d = 1'b1;
    end else if (absorb) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      run_q   <= 1'b1;
      pend_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      pend_q  <= pend_d;
      word_q  <= word_d;
    end
  end

  assign running = run_q;
  assign pend    = pend_q;
  assign posted  = word_q;

  AST_RUN_ON_ABSORB: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_q != $past(run_q)) |-> $past(pend_q && tick)); // R4
  AST_PEND_AFTER_POST: assert property (@(posedge clk) disable iff (!rst_ni)
    post_wr |=> pend_q); // R5
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic             cfg_en,
  input  logic [PTV_W-1:0] cfg_ptv,
  output logic             adv
);
  localparam int PRE_W = (1 << PTV_W) - 1;

  logic             act_en_q, act_en_d;
  logic [PTV_W-1:0] act_ptv_q, act_ptv_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W:0]   span, lim_full;
  logic             step;

  always_comb begin
    span     = {{PRE_W{1'b0}}, 1'b1} << act_ptv_q;
    lim_full = span - 1'b1;
    step     = tick & run;
    adv      = step & (~act_en_q | (pre_q == lim_full[PRE_W-1:0]));
    act_en_d  = act_en_q;
    act_ptv_d = act_ptv_q;
    pre_d     = pre_q;
    if (clr) begin
      pre_d     = '0;
      act_en_d  = cfg_en;
      act_ptv_d = cfg_ptv;
    end else if (step && act_en_q) begin
      pre_d = adv ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_q  <= 1'b0;
      act_ptv_q <= '0;
      pre_q     <= '0;
    end else begin
      act_en_q  <= act_en_d;
      act_ptv_q <= act_ptv_d;
      pre_q     <= pre_d;
    end
  end

  AST_PRE_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run && !clr) |=> $stable(pre_q)); // R3
  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (pre_q == '0)); // R6
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int          CNT_W    = 32,
  parameter logic [31:0] LOAD_RST = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             adv,
  input  logic             svc,
  input  logic [CNT_W-1:0] load_val,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             reload,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             ovf;

  always_comb begin
    ovf     = adv & (&cnt_q);
    reload  = svc | ovf;
    pulse_d = ovf & ~svc;
    cnt_d   = cnt_q;
    if (reload)      cnt_d = load_val;
    else if (wr_cnt) cnt_d = wr_val;
    else if (adv)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= LOAD_RST[CNT_W-1:0];
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign cnt   = cnt_q;
  assign pulse = pulse_q;

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    (!adv && !svc && !wr_cnt) |=> $stable(cnt_q)); // R2
  AST_PULSE_RELOADS: assert property (@(posedge clk) disable iff (!rst_ni)
    pulse_q |-> (cnt_q == $past(load_val))); // R7
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter int          PTV_W    = 3,
  parameter logic [31:0] LOAD_RST = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             wdt_rst_o
);
  localparam int HALF   = CNT_W / 2;
  localparam int EN_BIT = 2 + PTV_W;
  localparam int CFG_W  = PTV_W + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_i;
  logic [CNT_W-1:0] load_q, load_d;
  logic [CFG_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] svc_q, svc_d;
  logic [HALF-1:0]  shadow_q, shadow_d;
  logic [CNT_W-1:0] cnt;
  logic             running, pend, svc_hit, cnt_wr, reload, adv;
  logic [KEY_W-1:0] posted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  always_comb begin
    svc_hit  = wr_en && (addr == A_SERVICE) && (wdata != svc_q);
    cnt_wr   = wr_en && (addr == A_CNT) && !running;
    load_d   = load_q;
    psc_d    = psc_q;
    svc_d    = svc_q;
    shadow_d = shadow_q;
    if (wr_en && addr == A_LOAD && !running) load_d = wdata;
    if (wr_en && addr == A_PSC && !running)  psc_d = wdata[EN_BIT:2];
    if (wr_en && addr == A_SERVICE)          svc_d = wdata;
    if (rd_en && addr == A_CNT)              shadow_d = cnt[CNT_W-1:HALF];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      load_q   <= LOAD_RST[CNT_W-1:0];
      psc_q    <= '0;
      svc_q    <= '0;
      shadow_q <= '0;
    end else begin
      load_q   <= load_d;
      psc_q    <= psc_d;
      svc_q    <= svc_d;
      shadow_q <= shadow_d;
    end
  end

  kwdt_keyseq u_keys (
    .clk       (clk),
    .rst_ni    (rst_i),
    .tick      (tick_en),
    .post_wr   (wr_en && addr == A_RUNCTL),
    .post_word (wdata[KEY_W-1:0]),
    .running   (running),
    .pend      (pend),
    .posted    (posted)
  );

  kwdt_prescale #(.PTV_W(PTV_W)) u_psc (
    .clk     (clk),
    .rst_ni  (rst_i),
    .tick    (tick_en),
    .run     (running),
    .clr     (reload),
    .cfg_en  (psc_q[PTV_W]),
    .cfg_ptv (psc_q[PTV_W-1:0]),
    .adv     (adv)
  );

  kwdt_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk      (clk),
    .rst_ni   (rst_i),
    .adv      (adv),
    .svc      (svc_hit),
    .load_val (load_q),
    .wr_cnt   (cnt_wr),
    .wr_val   (wdata),
    .cnt      (cnt),
    .reload   (reload),
    .pulse    (wdt_rst_o)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_RUNCTL:  rdata[KEY_W-1:0] = posted;
      A_SERVICE: rdata = svc_q;
      A_LOAD:    rdata = load_q;
      A_PSC:     rdata[EN_BIT:2] = psc_q;
      A_CNT:     rdata[HALF-1:0] = cnt[HALF-1:0];
      A_CNTHI:   rdata[HALF-1:0] = shadow_q;
      A_STAT:    rdata[0] = pend;
      default:   rdata = '0;
    endcase
  end

  AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && addr == A_LOAD && running) |=> $stable(load_q)); // R9
  AST_SVC_RELOAD: assert property (@(posedge clk) disable iff (!rst_i)
    svc_hit |=> (cnt == $past(load_q))); // R6
  AST_SVC_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_i)
    svc_hit |=> !wdt_rst_o); // R11
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_i)
    !(rd_en && addr == A_CNT) |=> $stable(shadow_q)); // R10
endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;
  logic        clk = 1'b0;
  logic        rst_n, tick_en, wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        wdt_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_wdt u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wdt_rst_o(wdt_rst_o)
  );

  // reference model state
  logic [31:0] m_cnt, m_load, m_svc;
  logic [3:0]  m_psc;
  logic        m_aen;
  logic [2:0]  m_aptv;
  logic [6:0]  m_pre;
  logic        m_run, m_pend, m_pulse;
  logic [15:0] m_word, m_shadow;
  logic [1:0]  m_seq;

  task automatic model_reset();
    m_cnt = 32'hFFFF_0000; m_load = 32'hFFFF_0000; m_svc = '0; m_psc = '0;
    m_aen = 1'b0; m_aptv = '0; m_pre = '0; m_run = 1'b1; m_pend = 1'b0;
    m_pulse = 1'b0; m_word = '0; m_shadow = '0; m_seq = 2'd0;
  endtask

  function automatic logic [31:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return {16'h0, m_word};
      3'd1: return m_svc;
      3'd2: return m_load;
      3'd3: return {26'h0, m_psc, 2'b00};
      3'd4: return {16'h0, m_cnt[15:0]};
      3'd5: return {16'h0, m_shadow};
      3'd6: return {31'h0, m_pend};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(bit w, bit r, logic [2:0] a, logic [31:0] d, bit tk);
    logic [7:0]  lim;
    logic        hit, adv, ovf, absorb;
    logic [31:0] cnt_n;
    lim    = (8'd1 << m_aptv) - 8'd1;
    hit    = w && a == 3'd1 && d != m_svc;
    adv    = tk && m_run && (!m_aen || {1'b0, m_pre} == lim);
    ovf    = adv && m_cnt == 32'hFFFF_FFFF;
    absorb = m_pend && tk;
    if (hit || ovf)               cnt_n = m_load;
    else if (w && a == 3'd4 && !m_run) cnt_n = d;
    else if (adv)                 cnt_n = m_cnt + 1;
    else                          cnt_n = m_cnt;
    if (r && a == 3'd4) m_shadow = m_cnt[31:16];
    if (hit || ovf) begin
      m_pre = '0; m_aen = m_psc[3]; m_aptv = m_psc[2:0];
    end else if (tk && m_run && m_aen) begin
      m_pre = adv ? 7'd0 : m_pre + 7'd1;
    end
    m_pulse = ovf && !hit;
    if (absorb) begin
      if (m_seq == 2'd1 && m_word == 16'h5555) begin m_run = 1'b0; m_seq = 2'd0; end
      else if (m_seq == 2'd2 && m_word == 16'h4444) begin m_run = 1'b1; m_seq = 2'd0; end
      else if (m_word == 16'hAAAA) m_seq = 2'd1;
      else if (m_word == 16'hBBBB) m_seq = 2'd2;
      else m_seq = 2'd0;
    end
    if (w && a == 3'd0) begin m_word = d[15:0]; m_pend = 1'b1; end
    else if (absorb) m_pend = 1'b0;
    if (w && a == 3'd1) m_svc = d;
    if (w && a == 3'd2 && !m_run) m_load = d;
    if (w && a == 3'd3 && !m_run) m_psc = d[5:2];
    m_cnt = cnt_n;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit w, bit r, logic [2:0] a, logic [31:0] d, bit tk);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = tk;
    #1;
    if (r) check(tag, rdata, model_read(a));
    model_step(w, r, a, d, tk);
    @(posedge clk);
    #1;
    check({tag, " R7 reset request"}, {31'h0, wdt_rst_o}, {31'h0, m_pulse});
  endtask

  task automatic wreg(string tag, logic [2:0] a, logic [31:0] d);
    step(tag, 1'b1, 1'b0, a, d, 1'b0);
  endtask
  task automatic rreg(string tag, logic [2:0] a);
    step(tag, 1'b0, 1'b1, a, 32'h0, 1'b0);
  endtask
  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 3'd0, 32'h0, 1'b1);
  endtask
  task automatic key(string tag, logic [31:0] d);
    wreg(tag, 3'd0, d);
    step(tag, 1'b0, 1'b0, 3'd0, 32'h0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int first;
    logic [31:0] kw [5];
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) step("idle", 1'b0, 1'b0, 3'd0, 32'h0, 1'b0);

    // R1 reset state, read through all registers
    for (int a = 0; a < 8; a++) rreg("R1 reset value", 3'(a));

    // R1 default period: 65536 ticks to the first reset request
    first = 0;
    for (int i = 1; i <= 65540 && first == 0; i++) begin
      step("R1 default period", 1'b0, 1'b0, 3'd0, 32'h0, 1'b1);
      if (wdt_rst_o) first = i;
    end
    check("R1 ticks to first request", first, 65536);

    // R2 counting and holding without tick
    ticks("R2 count", 5);
    step("R2 hold", 1'b0, 1'b0, 3'd0, 32'h0, 1'b0);
    rreg("R2 count value", 3'd4);

    // R5 pending flag set, then cleared by tick; R4 stop sequence with upper bits set
    wreg("R5 post", 3'd0, 32'h1234_AAAA);
    rreg("R5 pending set", 3'd6);
    step("R5 absorb", 1'b0, 1'b0, 3'd0, 32'h0, 1'b1);
    rreg("R5 pending clear", 3'd6);
    key("R4 stop second", 32'hFFFF_5555);
    ticks("R4 stopped", 4);
    rreg("R4 stopped count", 3'd4);

    // R9 writes while stopped take hold; R8 deferred prescaler
    wreg("R9 load", 3'd2, 32'hFFFF_FFF0);
    wreg("R9 psc", 3'd3, 32'h0000_0024);
    wreg("R9 counter", 3'd4, 32'h0000_0005);
    rreg("R9 load readback", 3'd2);
    rreg("R9 counter readback", 3'd4);
    // R4 mismatch: AAAA then BBBB restarts with BBBB, then 4444 starts
    key("R4 restart", 32'h0000_AAAA);
    key("R4 restart", 32'h0000_BBBB);
    key("R4 restart", 32'h0000_4444);
    ticks("R8 old config", 3);
    rreg("R8 old config count", 3'd4);
    // R9 locked while running
    wreg("R9 locked load", 3'd2, 32'h0000_1111);
    rreg("R9 locked load read", 3'd2);
    wreg("R9 locked counter", 3'd4, 32'h0000_2222);
    rreg("R9 locked counter read", 3'd4);
    // R6 service reload, new prescaler applied (R3, R8)
    wreg("R6 service", 3'd1, 32'h0000_0001);
    rreg("R6 reloaded", 3'd4);
    wreg("R6 same value", 3'd1, 32'h0000_0001);
    ticks("R3 divide by two", 5);
    rreg("R3 divided count", 3'd4);
    ticks("R7 to overflow", 40);
    rreg("R7 after overflow", 3'd4);

    // R10 capture
    rreg("R10 low capture", 3'd4);
    ticks("R10 move", 7);
    rreg("R10 high from capture", 3'd5);

    // R4 bad second word ignored
    key("R4 bad", 32'h0000_AAAA);
    key("R4 bad", 32'h0000_1234);
    key("R4 bad", 32'h0000_5555);
    ticks("R4 still running", 3);
    rreg("R4 still running count", 3'd4);

    // R11 service write and overflow in one cycle
    key("R11 setup", 32'h0000_AAAA);
    key("R11 setup", 32'h0000_5555);
    wreg("R11 setup", 3'd3, 32'h0);
    wreg("R11 setup", 3'd2, 32'h0000_0100);
    wreg("R11 setup", 3'd1, 32'h0000_0077);
    wreg("R11 setup", 3'd4, 32'hFFFF_FFFF);
    key("R11 setup", 32'h0000_BBBB);
    key("R11 setup", 32'h0000_4444);
    step("R11 collide", 1'b1, 1'b0, 3'd1, 32'h0000_0099, 1'b1);
    check("R11 no request", {31'h0, wdt_rst_o}, 32'h0);
    rreg("R11 single reload", 3'd4);

    // random traffic
    kw[0] = 32'hAAAA; kw[1] = 32'h5555; kw[2] = 32'hBBBB; kw[3] = 32'h4444; kw[4] = 32'h0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6000; i++) begin
      bit w, r, tk;
      logic [2:0]  a;
      logic [31:0] d;
      w  = ($urandom % 4) == 0;
      r  = ($urandom % 3) == 0;
      tk = ($urandom % 2) == 0;
      a  = 3'($urandom % 8);
      d  = $urandom;
      if (w && a == 3'd0) d = {d[31:16], kw[$urandom % 5][15:0] | (($urandom % 5 == 0) ? d[15:0] : 16'h0)};
      if (w && (a == 3'd2 || a == 3'd4)) d = 32'hFFFF_FF00 | (d & 32'hFF);
      if (w && a == 3'd3) d = d & 32'h3C;
      if (w && a == 3'd1 && ($urandom % 2)) d = m_svc;
      step("R2 R3 R4 R6 R10 random", w, r, a, d, tk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule